// File: doc/BRIEF.md
# Smart-Card Half-Duplex UART with Parity NACK

This block is a half-duplex asynchronous transceiver for a smart-card link. The link is a single data line with an external pull-up. The block only ever pulls that line low. Releasing the line is how it signals a one. It sends and receives 8-bit characters, each protected by an even parity bit. Bit timing comes from an oversampling strobe (`tick`) that a baud generator outside the block provides. One bit lasts `OVS` strobes.

When a received character fails its parity check and error signalling is enabled, the block answers the card with a NACK. About half a bit after sampling the stop bit, it starts pulling the line low. It keeps the line low until software reads the receive buffer. When it transmits, the block samples the line at the instant it raises transmit-complete. Software can then tell from that sample whether the card pulled the line low to reject the character. While the block is driving the line itself, its receiver does not listen, so its own traffic is never taken for a received character.

Top module: `sc_uart`

## Requirements
- R1: A transmitted frame is a low start bit, then data bits 0 to 7 (least significant first), then a parity bit that makes the count of ones in data plus parity even, then a high stop bit. Each bit lasts OVS ticks. `line_pull` is 1 exactly where a frame bit is 0.
- R2: `tx_done` is a single-cycle pulse raised when the stop bit's OVS ticks end, that is 11*OVS ticks after the write is accepted.
- R3: `tx_line_seen` holds the synchronised line level captured in the cycle that raises `tx_done`. It reads 0 when the card is holding the line low at that moment.
- R4: The receiver confirms a start bit only if the line is still low OVS/2 ticks after the falling edge. It then samples each later bit once per OVS ticks. It raises a single-cycle `rx_done` at the stop-bit sample and loads `rx_data` in the same cycle.
- R5: `rx_perr` is updated with every `rx_done`. It becomes 1 when data and parity together hold an odd number of ones, and 0 otherwise.
- R6: A low pulse shorter than half a bit produces no `rx_done`.
- R7: With `err_en`=1, a parity error makes the block pull the line low once OVS/2 ticks have passed after `rx_done`. No pull appears before then. The pull lasts until `rx_rd` is asserted. A character with good parity produces no pull.
- R8: On the clock edge that samples `rx_rd`, both `rx_perr` and the NACK pull return to 0. If a new `rx_done` occurs in that same cycle, the new result wins.
- R9: With `err_en`=0, a parity error still sets `rx_perr` but never pulls the line.
- R10: While the block is transmitting or driving a NACK, its receiver ignores the line. After that it waits to see the line high before it accepts a new start.
- R11: A `tx_wr` that arrives while `tx_busy`=1 is ignored. The frame in progress is unchanged and no extra frame follows.
- R12: After reset `line_pull`=0, `tx_busy`=0, `rx_perr`=0, `rx_done`=0, `tx_done`=0 and `tx_line_seen`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Oversampling strobe, OVS per bit |
| tx_wr | input | 1 | Write a character to transmit |
| tx_data | input | DW | Character to transmit |
| tx_busy | output | 1 | Transmitter is sending a frame |
| tx_done | output | 1 | One-cycle pulse at the end of the stop bit |
| tx_line_seen | output | 1 | Line level sampled at transmit complete |
| rx_rd | input | 1 | Read strobe of the receive buffer |
| rx_data | output | DW | Last received character |
| rx_perr | output | 1 | Parity-error flag of the last character |
| rx_done | output | 1 | One-cycle pulse at the stop-bit sample |
| err_en | input | 1 | Enable NACK drive on parity error |
| line_in | input | 1 | Level of the shared line |
| line_pull | output | 1 | 1 pulls the shared line low, 0 releases it |

## Verification
The hardest states to reach are the ones where the block is the only thing holding the line low, or where the card holds it low just after the block has finished sending. Stimulus reaches them through a card model that shares a wired-AND line with the block. The model sends frames with parity deliberately flipped, with the NACK enable both on and off. It also holds the line low across the end of selected transmitted frames. The bench then checks that the NACK appears only after the half-bit delay, that it persists, and that it drops on the read edge. It also checks that the line held low after a transmission is reported to software but never turns into a spurious received character.

// File: rtl/scu_pkg.sv
package scu_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_st_t;
  typedef enum logic [1:0] {NK_OFF, NK_WAIT, NK_HOLD} nk_st_t;
endpackage

// File: rtl/scu_tx.sv
module scu_tx #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          line_s,
  output logic          busy,
  output logic          pull,
  output logic          done,
  output logic          seen
);
  localparam int TW = $clog2(OVS);
  localparam int FL = DW + 3;
  localparam int BW = $clog2(FL);

  logic          busy_q, busy_d;
  logic [FL-1:0] sh_q, sh_d;
  logic [TW-1:0] tc_q, tc_d;
  logic [BW-1:0] bc_q, bc_d;
  logic          done_q, done_d;
  logic          seen_q, seen_d;

  always_comb begin
    busy_d = busy_q;
    sh_d   = sh_q;
    tc_d   = tc_q;
    bc_d   = bc_q;
    done_d = 1'b0;
    seen_d = seen_q;
    if (!busy_q) begin
      if (wr) begin
        busy_d = 1'b1;
        sh_d   = {1'b1, ^wdata, wdata, 1'b0};
        tc_d   = '0;
        bc_d   = '0;
      end
    end else if (tick) begin
      if (tc_q == TW'(OVS - 1)) begin
        tc_d = '0;
        if (bc_q == BW'(FL - 1)) begin
          busy_d = 1'b0;
          done_d = 1'b1;
          seen_d = line_s;
        end else begin
          bc_d = bc_q + 1'b1;
          sh_d = {1'b1, sh_q[FL-1:1]};
        end
      end else begin
        tc_d = tc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      tc_q   <= '0;
      bc_q   <= '0;
      done_q <= 1'b0;
      seen_q <= 1'b1;
    end else begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
      tc_q   <= tc_d;
      bc_q   <= bc_d;
      done_q <= done_d;
      seen_q <= seen_d;
    end
  end

  assign busy = busy_q;
  assign pull = busy_q & ~sh_q[0];
  assign done = done_q;
  assign seen = seen_q;
endmodule

// File: rtl/scu_rx.sv
module scu_rx
  import scu_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          line_s,
  input  logic          mask,
  input  logic          rd,
  output logic [DW-1:0] data,
  output logic          perr,
  output logic          done
);
  localparam int TW   = $clog2(OVS);
  localparam int HALF = OVS / 2;
  localparam int BW   = $clog2(DW + 2);

  rx_st_t        st_q, st_d;
  logic          armed_q, armed_d;
  logic [TW-1:0] tc_q, tc_d;
  logic [BW-1:0] bc_q, bc_d;
  logic [DW:0]   sh_q, sh_d;
  logic [DW-1:0] data_q, data_d;
  logic          perr_q, perr_d;
  logic          done_q, done_d;

  always_comb begin
    st_d    = st_q;
    armed_d = armed_q;
    tc_d    = tc_q;
    bc_d    = bc_q;
    sh_d    = sh_q;
    data_d  = data_q;
    perr_d  = perr_q;
    done_d  = 1'b0;
    if (rd) perr_d = 1'b0;
    case (st_q)
      RX_IDLE: begin
        if (mask)        armed_d = 1'b0;
        else if (line_s) armed_d = 1'b1;
        else if (armed_q) begin
          st_d = RX_START;
          tc_d = '0;
        end
      end
      RX_START: begin
        if (mask) st_d = RX_IDLE;
        else if (tick) begin
          if (tc_q == TW'(HALF - 1)) begin
            tc_d = '0;
            bc_d = '0;
            st_d = line_s ? RX_IDLE : RX_BITS;
          end else begin
            tc_d = tc_q + 1'b1;
          end
        end
      end
      RX_BITS: begin
        if (mask) st_d = RX_IDLE;
        else if (tick) begin
          if (tc_q == TW'(OVS - 1)) begin
            tc_d = '0;
            if (bc_q == BW'(DW + 1)) begin
              st_d    = RX_IDLE;
              armed_d = 1'b0;
              done_d  = 1'b1;
              data_d  = sh_q[DW-1:0];
              perr_d  = ^sh_q;
            end else begin
              sh_d = {line_s, sh_q[DW:1]};
              bc_d = bc_q + 1'b1;
            end
          end else begin
            tc_d = tc_q + 1'b1;
          end
        end
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      armed_q <= 1'b0;
      tc_q    <= '0;
      bc_q    <= '0;
      sh_q    <= '0;
      data_q  <= '0;
      perr_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      armed_q <= armed_d;
      tc_q    <= tc_d;
      bc_q    <= bc_d;
      sh_q    <= sh_d;
      data_q  <= data_d;
      perr_q  <= perr_d;
      done_q  <= done_d;
    end
  end

  assign data = data_q;
  assign perr = perr_q;
  assign done = done_q;
endmodule

// File: rtl/scu_nack.sv
module scu_nack
  import scu_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic done,
  input  logic perr,
  input  logic en,
  input  logic rd,
  output logic pull
);
  localparam int TW   = $clog2(OVS);
  localparam int HALF = OVS / 2;

  nk_st_t        st_q, st_d;
  logic [TW-1:0] tc_q, tc_d;

  always_comb begin
    st_d = st_q;
    tc_d = tc_q;
    case (st_q)
      NK_WAIT: begin
        if (tick) begin
          if (tc_q == TW'(HALF - 1)) begin
            st_d = NK_HOLD;
            tc_d = '0;
          end else begin
            tc_d = tc_q + 1'b1;
          end
        end
      end
      default: ;
    endcase
    if (rd) st_d = NK_OFF;
    if (done) begin
      tc_d = '0;
      st_d = (perr && en) ? NK_WAIT : NK_OFF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= NK_OFF;
      tc_q <= '0;
    end else begin
      st_q <= st_d;
      tc_q <= tc_d;
    end
  end

  assign pull = (st_q == NK_HOLD) & en;
endmodule

// File: rtl/sc_uart.sv
module sc_uart #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_data,
  output logic          tx_busy,
  output logic          tx_done,
  output logic          tx_line_seen,
  input  logic          rx_rd,
  output logic [DW-1:0] rx_data,
  output logic          rx_perr,
  output logic          rx_done,
  input  logic          err_en,
  input  logic          line_in,
  output logic          line_pull
);
  logic rs1_q, rs2_q;
  logic ls1_q, ls2_q;
  logic tx_pull, nack_pull, rx_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end

  always_ff @(posedge clk or negedge rs2_q) begin
    if (!rs2_q) begin
      ls1_q <= 1'b1;
      ls2_q <= 1'b1;
    end else begin
      ls1_q <= line_in;
      ls2_q <= ls1_q;
    end
  end

  assign rx_mask = tx_busy | nack_pull;

  scu_tx #(.DW(DW), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rs2_q), .tick(tick), .wr(tx_wr), .wdata(tx_data),
    .line_s(ls2_q), .busy(tx_busy), .pull(tx_pull), .done(tx_done),
    .seen(tx_line_seen)
  );

  scu_rx #(.DW(DW), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rs2_q), .tick(tick), .line_s(ls2_q), .mask(rx_mask),
    .rd(rx_rd), .data(rx_data), .perr(rx_perr), .done(rx_done)
  );

  scu_nack #(.OVS(OVS)) u_nack (
    .clk(clk), .rst_n(rs2_q), .tick(tick), .done(rx_done), .perr(rx_perr),
    .en(err_en), .rd(rx_rd), .pull(nack_pull)
  );

  assign line_pull = tx_pull | nack_pull;
endmodule

// File: rtl/scu_chk.sv
module scu_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_busy,
  input logic tx_done,
  input logic tx_pull,
  input logic rx_done,
  input logic rx_perr,
  input logic rx_rd,
  input logic nack_pull
);
  assert_tx_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);

  assert_rx_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  assert_nack_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_perr |-> !nack_pull);

  assert_read_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && !rx_done) |=> (rx_done || (!rx_perr && !nack_pull)));

  assert_no_echo_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && $past(tx_busy)) |-> !rx_done);

  assert_frame_runs_on_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |=> (tx_busy || tx_done));

  assert_idle_released_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> !tx_pull);
endmodule

bind sc_uart scu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_busy(tx_busy), .tx_done(tx_done),
  .tx_pull(tx_pull), .rx_done(rx_done), .rx_perr(rx_perr), .rx_rd(rx_rd),
  .nack_pull(nack_pull)
);

// File: tb/scu_pin.sv
module scu_pin #(
  parameter int N = 2
) (
  input  logic [N-1:0] pulls,
  output logic         line
);
  assign line = ~|pulls;
endmodule

// File: tb/sim_sc_uart.sv
module sim_sc_uart;
  localparam int OVS = 4;

  logic clk, rst_n, tick, tx_wr, rx_rd, err_en, card_pull;
  logic [7:0] tx_data, rx_data;
  logic tx_busy, tx_done, tx_line_seen, rx_done, rx_perr, line_pull, line;
  int cyc, n_chk, n_bad, n_rxd, last_rxd, n_txd, last_txd, tdiv;
  bit finished;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  scu_pin #(.N(2)) u_pin (.pulls({card_pull, line_pull}), .line(line));

  sc_uart #(.DW(8), .OVS(OVS)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tx_wr(tx_wr), .tx_data(tx_data),
    .tx_busy(tx_busy), .tx_done(tx_done), .tx_line_seen(tx_line_seen),
    .rx_rd(rx_rd), .rx_data(rx_data), .rx_perr(rx_perr), .rx_done(rx_done),
    .err_en(err_en), .line_in(line), .line_pull(line_pull)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    tick <= (tdiv == 3);
    tdiv <= (tdiv + 1) % 4;
  end

  always @(posedge clk) begin
    #1;
    if (rx_done === 1'b1) begin n_rxd++; last_rxd = cyc; end
    if (tx_done === 1'b1) begin n_txd++; last_txd = cyc; end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic tx_frame(input logic [7:0] b, input bit card_err, input bit extra_wr);
    logic [10:0] f, obs;
    int w, rx0, tx0;
    f = {1'b1, ^b, b, 1'b0};
    rx0 = n_rxd; tx0 = n_txd;
    @(negedge clk); tx_data = b; tx_wr = 1'b1; w = cyc;
    @(negedge clk); tx_wr = 1'b0;
    for (int i = 0; i < 11; i++) begin
      if (extra_wr && i == 3) begin
        tx_data = ~b; tx_wr = 1'b1; @(negedge clk); tx_wr = 1'b0;
      end
      wait_until(w + 8 + 16 * i);
      obs[i] = ~line_pull;
    end
    chk(obs == f, "R1", "frame bits", int'(obs), int'(f));
    wait_until(w + 168);
    if (card_err) card_pull = 1'b1;
    wait_until(w + 182);
    chk(n_txd == tx0 + 1, "R2", "tx_done count", n_txd - tx0, 1);
    chk(last_txd >= w + 172 && last_txd <= w + 180, "R2", "tx_done offset",
        last_txd - w, 176);
    chk(tx_line_seen == !card_err, "R3", "line seen", int'(tx_line_seen), int'(!card_err));
    wait_until(w + 196);
    card_pull = 1'b0;
    wait_until(w + 204);
    chk(n_rxd == rx0, "R10", "rx_done during own traffic", n_rxd - rx0, 0);
    if (extra_wr)
      chk(!tx_busy && !line_pull && n_txd == tx0 + 1, "R11", "write while busy",
          n_txd - tx0, 1);
  endtask

  task automatic rx_frame(input logic [7:0] b, input bit bad);
    logic [10:0] f;
    int s, rx0;
    f = {1'b1, (^b) ^ bad, b, 1'b0};
    @(negedge clk);
    rx0 = n_rxd; s = cyc;
    for (int i = 0; i < 10; i++) begin
      card_pull = ~f[i];
      repeat (16) @(negedge clk);
    end
    card_pull = 1'b0;
    wait_until(s + 172);
    chk(!line_pull, "R7", "no pull before half bit", int'(line_pull), 0);
    wait_until(s + 176);
    chk(n_rxd == rx0 + 1, "R4", "rx_done count", n_rxd - rx0, 1);
    chk(last_rxd >= s + 165 && last_rxd <= s + 174, "R4", "rx_done offset",
        last_rxd - s, 170);
    chk(rx_data == b, "R4", "rx_data", int'(rx_data), int'(b));
    chk(rx_perr == bad, "R5", "parity flag", int'(rx_perr), int'(bad));
  endtask

  task automatic read_buf();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  initial begin
    cyc = 0; n_chk = 0; n_bad = 0; n_rxd = 0; n_txd = 0; tdiv = 0;
    last_rxd = 0; last_txd = 0; finished = 1'b0;
    rst_n = 1'b0; tick = 1'b0; tx_wr = 1'b0; rx_rd = 1'b0; err_en = 1'b0;
    card_pull = 1'b0; tx_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!line_pull && !tx_busy && !rx_perr && !rx_done && !tx_done && tx_line_seen,
        "R12", "reset state", int'({line_pull, tx_busy, rx_perr, rx_done, tx_done, tx_line_seen}), 1);

    // R4 R5: every character, parity corrupted on a third of them
    for (int b = 0; b < 256; b++) begin
      rx_frame(8'(b), (b % 3) == 1);
      repeat (8) @(negedge clk);
    end

    // R1 R2 R3 R10 R11: every character sent, card objects to some
    for (int b = 0; b < 256; b++) tx_frame(8'(b), (b % 5) == 0, (b % 37) == 3);

    // R7 R8: NACK drive and release
    err_en = 1'b1;
    rx_frame(8'h3C, 1'b1);
    wait_until(last_rxd + 12);
    chk(line_pull && !line, "R7", "nack drive", int'(line_pull), 1);
    begin
      int r0;
      r0 = n_rxd;
      repeat (100) @(negedge clk);
      chk(line_pull && rx_perr, "R7", "nack held", int'(line_pull), 1);
      chk(n_rxd == r0, "R10", "own nack ignored", n_rxd - r0, 0);
    end
    read_buf();
    chk(!line_pull && !rx_perr && line, "R8", "read releases", int'({line_pull, rx_perr}), 0);

    // R7: good parity with enable set gives no drive
    rx_frame(8'h81, 1'b0);
    wait_until(last_rxd + 12);
    chk(!line_pull, "R7", "no nack on good parity", int'(line_pull), 0);

    // R9: disabled error signalling
    err_en = 1'b0;
    rx_frame(8'h7E, 1'b1);
    wait_until(last_rxd + 12);
    chk(!line_pull && rx_perr, "R9", "disabled nack", int'({line_pull, rx_perr}), 1);
    read_buf();
    chk(!rx_perr, "R8", "read clears flag", int'(rx_perr), 0);

    // R6: short low glitch
    begin
      int r0;
      r0 = n_rxd;
      @(negedge clk); card_pull = 1'b1;
      repeat (3) @(negedge clk); card_pull = 1'b0;
      repeat (200) @(negedge clk);
      chk(n_rxd == r0, "R6", "glitch rejected", n_rxd - r0, 0);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    wait (cyc >= 195000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R4: actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule